// File: doc/BRIEF.md
# Dual-Slot Receive Buffer Controller

This block arbitrates two receive buffer slots between a MAC receive path and host software. Software arms a slot by writing the value "loaded" into that slot's state register. When the MAC signals the start of a frame, the controller commits the frame to an armed slot, with slot 0 ahead of slot 1. It reports the committed slot to the MAC so the MAC can steer its buffer writes. If no slot is armed, the frame is dropped and nothing changes.

When the frame ends, the MAC presents the payload byte count. The controller pads short payloads to the minimum frame size and adds the fixed framing overhead. It writes the result into the slot's count register and marks the slot pending. A payload that would overflow the slot's buffer is rejected, and that slot keeps its state and count. A level interrupt stays high while any slot is pending. A can-receive flag tells the MAC that at least one slot is armed. Host access is through a word-addressed 32-bit register file that also holds three plain control words used by neighbouring logic.

Top module: `rxbuf_dual_slot_ctrl`

## Requirements
- R1: After reset all seven registers read zero, both slots are empty, and `rx_irq`, `can_rx` and `cur_valid` are low.
- R2: A slot state holds 0 for empty, 1 for loaded and 2 for pending. Slot 0's state is at word address 2 and its count at 3. Slot 1's state is at 4 and its count at 5. A write to a state address stores bits [1:0] and reads back zero-extended. `can_rx` is high exactly while at least one state equals 1.
- R3: On `frm_start`, the frame is committed to slot 0 if slot 0 is loaded, otherwise to slot 1 if slot 1 is loaded. From the next cycle `cur_valid` is 1 and `cur_slot` gives the slot index.
- R4: On `frm_start` with no slot loaded, `cur_valid` stays 0. The following `frm_done` changes no state or count register and leaves `rx_irq` unchanged.
- R5: On `frm_done` for a committed frame with payload length L, the slot's count becomes max(L,60)+12 and its state becomes 2. Both are visible in the cycle after `frm_done`.
- R6: If L+12 exceeds 2048, the frame is rejected and the committed slot's state and count are unchanged. L = 2036 is accepted with count 2048.
- R7: `rx_irq` is high exactly while at least one slot state equals 2. It falls after a software write that leaves no slot pending.
- R8: A committed frame stays with its slot until `frm_done`, even if software arms the other slot in the meantime. The other slot's state is not touched by the completion.
- R9: Word addresses 0, 1 and 6 are 32-bit read/write storage. Reads of any address above 6 return zero, and writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| frm_start | input | 1 | MAC pulse: a frame begins |
| frm_done | input | 1 | MAC pulse: the frame ends, `frm_len` valid |
| frm_len | input | 16 | Payload byte count of the ending frame |
| cur_valid | output | 1 | A frame is committed to a slot |
| cur_slot | output | 1 | Index of the committed slot |
| can_rx | output | 1 | At least one slot is loaded |
| rx_irq | output | 1 | Level receive interrupt |

## Verification
A wrong slot state shows at the ports right away: a stuck or misdecoded state shifts `can_rx` or `rx_irq` in the cycle after the write or completion that set it. A mis-steered commitment shows as `cur_slot` pointing at the wrong index one cycle after `frm_start`, and as the pending mark and count landing in the other slot's registers one cycle after `frm_done`. Errors in length arithmetic are exposed at the padding knee (payload below 60 bytes) and at the overflow knee (2036 versus 2037 bytes). The rejected case must leave the armed slot still loaded.

// File: rtl/rxc_pkg.sv
// Shared constants for the dual-slot receive controller: slot state
// encodings and the register word map. Assumes word addressing.
package rxc_pkg;
    localparam logic [1:0] SLOT_EMPTY   = 2'd0;
    localparam logic [1:0] SLOT_LOADED  = 2'd1;
    localparam logic [1:0] SLOT_PENDING = 2'd2;

    localparam int ADR_SETUP  = 0;
    localparam int ADR_MDIO   = 1;
    localparam int ADR_STATE0 = 2;
    localparam int ADR_TXCNT  = 6;
    localparam int NUM_REGS   = 7;
endpackage

// File: rtl/rxc_len_calc.sv
// Computes the stored frame length from a payload byte count: pads up to
// the minimum payload, adds the framing overhead, and flags payloads that
// would not fit the slot buffer. Purely combinational.
module rxc_len_calc #(
    parameter int LEN_W       = 16,
    parameter int CNT_W       = 12,
    parameter int BUF_BYTES   = 2048,
    parameter int OVERHEAD    = 12,
    parameter int MIN_PAYLOAD = 60
) (
    input  logic [LEN_W-1:0] pay_len,
    output logic [CNT_W-1:0] frame_len,
    output logic             too_big
);
    logic [31:0] ext_len;
    logic [31:0] padded;
    logic [31:0] total;

    // Pad, add overhead and compare against the buffer size.
    always_comb begin
        ext_len   = 32'(pay_len);
        padded    = (ext_len < 32'(MIN_PAYLOAD)) ? 32'(MIN_PAYLOAD) : ext_len;
        total     = padded + 32'(OVERHEAD);
        too_big   = (ext_len + 32'(OVERHEAD)) > 32'(BUF_BYTES);
        frame_len = total[CNT_W-1:0];
    end
endmodule

// File: rtl/rxc_arbiter.sv
// Commits an arriving frame to the lowest-index loaded slot and holds that
// choice until the frame ends. Assumes frm_start and frm_done are pulses
// from the MAC; a start with no loaded slot leaves nothing committed.
module rxc_arbiter #(
    parameter int NSLOT = 2,
    localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_start,
    input  logic             frm_done,
    input  logic [NSLOT-1:0] slot_loaded,
    output logic             act_q,
    output logic [SEL_W-1:0] sel_q
);
    logic             any_loaded;
    logic [SEL_W-1:0] first_idx;

    // Fixed-priority search, lowest index wins.
    always_comb begin
        any_loaded = 1'b0;
        first_idx  = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (slot_loaded[i]) begin
                any_loaded = 1'b1;
                first_idx  = SEL_W'(i);
            end
        end
    end

    // Commit on start, release on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            sel_q <= '0;
        end else if (frm_start) begin
            act_q <= any_loaded;
            sel_q <= first_idx;
        end else if (frm_done) begin
            act_q <= 1'b0;
        end
    end

    // R3
    slot0_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start && slot_loaded[0] |=> act_q && (sel_q == '0));
    // R4
    no_slot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start && (slot_loaded == '0) |=> !act_q);
    // R8
    commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_q && !frm_start && !frm_done |=> act_q && $stable(sel_q));
endmodule

// File: rtl/rxc_slot.sv
// One receive slot: a state register and a byte-count register, written by
// software through the register bus and by the hardware on frame completion.
// Assumes a completion and a software write to the same register in one
// cycle resolve in favour of the completion.
module rxc_slot #(
    parameter int IDX   = 0,
    parameter int CNT_W = 12,
    parameter int ADR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic             hw_cmp,
    input  logic [CNT_W-1:0] hw_len,
    output logic [1:0]       state_q,
    output logic [CNT_W-1:0] count_q
);
    import rxc_pkg::*;

    localparam logic [ADR_W-1:0] ST_ADR  = ADR_W'(ADR_STATE0 + 2 * IDX);
    localparam logic [ADR_W-1:0] CNT_ADR = ADR_W'(ADR_STATE0 + 2 * IDX + 1);

    // State register: completion marks pending, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SLOT_EMPTY;
        else if (hw_cmp)
            state_q <= SLOT_PENDING;
        else if (bus_wr && bus_addr == ST_ADR)
            state_q <= bus_wdata[1:0];
    end

    // Count register: completion stores length, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (hw_cmp)
            count_q <= hw_len;
        else if (bus_wr && bus_addr == CNT_ADR)
            count_q <= bus_wdata[CNT_W-1:0];
    end

    // R5
    complete_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_cmp |=> (state_q == SLOT_PENDING) && (count_q == $past(hw_len)));
endmodule

// File: rtl/rxbuf_dual_slot_ctrl.sv
// Top of the dual-slot receive controller: register file, slot arbitration,
// length computation, interrupt and can-receive flags. Assumes single-cycle
// 32-bit register accesses with combinational read data.
module rxbuf_dual_slot_ctrl #(
    parameter int ADR_W       = 4,
    parameter int LEN_W       = 16,
    parameter int BUF_BYTES   = 2048,
    parameter int OVERHEAD    = 12,
    parameter int MIN_PAYLOAD = 60,
    localparam int NSLOT = 2,
    localparam int CNT_W = $clog2(BUF_BYTES) + 1,
    localparam int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             frm_start,
    input  logic             frm_done,
    input  logic [LEN_W-1:0] frm_len,
    output logic             cur_valid,
    output logic [SEL_W-1:0] cur_slot,
    output logic             can_rx,
    output logic             rx_irq
);
    import rxc_pkg::*;

    logic [31:0]      setup_q, mdio_q, txcnt_q;
    logic [1:0]       st     [NSLOT];
    logic [CNT_W-1:0] cnt    [NSLOT];
    logic [NSLOT-1:0] loaded, pending, cmp;
    logic [CNT_W-1:0] frame_len;
    logic             too_big;
    logic             accept;

    rxc_len_calc #(
        .LEN_W(LEN_W), .CNT_W(CNT_W), .BUF_BYTES(BUF_BYTES),
        .OVERHEAD(OVERHEAD), .MIN_PAYLOAD(MIN_PAYLOAD)
    ) u_len (
        .pay_len(frm_len), .frame_len(frame_len), .too_big(too_big)
    );

    rxc_arbiter #(.NSLOT(NSLOT)) u_arb (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_done(frm_done),
        .slot_loaded(loaded), .act_q(cur_valid), .sel_q(cur_slot)
    );

    // Completion is taken only for a committed, fitting frame.
    assign accept = frm_done && cur_valid && !too_big;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign cmp[g]     = accept && (cur_slot == SEL_W'(g));
        assign loaded[g]  = (st[g] == SLOT_LOADED);
        assign pending[g] = (st[g] == SLOT_PENDING);

        rxc_slot #(.IDX(g), .CNT_W(CNT_W), .ADR_W(ADR_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
            .bus_wdata(bus_wdata), .hw_cmp(cmp[g]), .hw_len(frame_len),
            .state_q(st[g]), .count_q(cnt[g])
        );
    end

    assign can_rx = |loaded;
    assign rx_irq = |pending;

    // Plain control words kept for neighbouring logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
            mdio_q  <= '0;
            txcnt_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADR_W'(ADR_SETUP)) setup_q <= bus_wdata;
            if (bus_addr == ADR_W'(ADR_MDIO))  mdio_q  <= bus_wdata;
            if (bus_addr == ADR_W'(ADR_TXCNT)) txcnt_q <= bus_wdata;
        end
    end

    // Read mux over the seven-word map; everything else reads zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_W'(ADR_SETUP)) bus_rdata = setup_q;
        if (bus_addr == ADR_W'(ADR_MDIO))  bus_rdata = mdio_q;
        if (bus_addr == ADR_W'(ADR_TXCNT)) bus_rdata = txcnt_q;
        for (int i = 0; i < NSLOT; i++) begin
            if (bus_addr == ADR_W'(ADR_STATE0 + 2 * i))
                bus_rdata = {30'd0, st[i]};
            if (bus_addr == ADR_W'(ADR_STATE0 + 2 * i + 1))
                bus_rdata = {{(32 - CNT_W){1'b0}}, cnt[i]};
        end
    end

    // R6
    reject_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && cur_valid && too_big && !bus_wr
        |=> $stable(st[0]) && $stable(st[1]) && $stable(cnt[0]) && $stable(cnt[1]));
    // R4
    drop_keeps_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && !cur_valid && !bus_wr
        |=> $stable(st[0]) && $stable(st[1]) && $stable(cnt[0]) && $stable(cnt[1]));
    // R9
    outside_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr >= ADR_W'(NUM_REGS)) && !frm_done
        |=> $stable(setup_q) && $stable(mdio_q) && $stable(txcnt_q)
            && $stable(st[0]) && $stable(st[1]) && $stable(cnt[0]) && $stable(cnt[1]));
    // R7
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(frm_done) || $past(bus_wr));
endmodule

// File: tb/sim_rxbuf_dual_slot_ctrl.sv
// Directed bench for the dual-slot receive controller.
module sim_rxbuf_dual_slot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frm_start = 1'b0;
    logic        frm_done = 1'b0;
    logic [15:0] frm_len = '0;
    logic        cur_valid;
    logic [0:0]  cur_slot;
    logic        can_rx;
    logic        rx_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    rxbuf_dual_slot_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frm_start(frm_start),
        .frm_done(frm_done), .frm_len(frm_len), .cur_valid(cur_valid),
        .cur_slot(cur_slot), .can_rx(can_rx), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        bus_addr = 4'(a);
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic start_frame();
        @(negedge clk); frm_start = 1'b1;
        @(negedge clk); frm_start = 1'b0;
    endtask

    task automatic end_frame(input int len);
        @(negedge clk); frm_done = 1'b1; frm_len = 16'(len);
        @(negedge clk); frm_done = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 7; a++) rd_chk("R1 reg zero", a, 0);
        chk("R1 irq", 32'(rx_irq), 0);
        chk("R1 can_rx", 32'(can_rx), 0);
        chk("R1 cur_valid", 32'(cur_valid), 0);
    endtask

    task automatic t_map();
        wr(0, 32'hA5A5_0001);
        wr(1, 32'h0000_000F);
        wr(6, 32'h0000_0123);
        rd_chk("R9 setup", 0, 32'hA5A5_0001);
        rd_chk("R9 mdio", 1, 32'h0000_000F);
        rd_chk("R9 txcount", 6, 32'h0000_0123);
        wr(7, 32'hFFFF_FFFF);
        wr(15, 32'hFFFF_FFFF);
        rd_chk("R9 outside 7", 7, 0);
        rd_chk("R9 outside 15", 15, 0);
        rd_chk("R9 setup kept", 0, 32'hA5A5_0001);
        rd_chk("R9 state0 kept", 2, 0);
        rd_chk("R9 txcount kept", 6, 32'h0000_0123);
    endtask

    task automatic t_state_rw();
        wr(2, 1);
        rd_chk("R2 state0 loaded", 2, 1);
        chk("R2 can_rx high", 32'(can_rx), 1);
        wr(2, 0);
        chk("R2 can_rx low", 32'(can_rx), 0);
        wr(4, 1);
        chk("R2 can_rx slot1", 32'(can_rx), 1);
        wr(4, 0);
    endtask

    task automatic t_drop();
        start_frame();
        chk("R4 no commit", 32'(cur_valid), 0);
        end_frame(100);
        rd_chk("R4 state0", 2, 0);
        rd_chk("R4 count0", 3, 0);
        rd_chk("R4 state1", 4, 0);
        rd_chk("R4 count1", 5, 0);
        chk("R4 irq", 32'(rx_irq), 0);
    endtask

    task automatic t_receive();
        wr(2, 1); wr(4, 1);
        start_frame();
        chk("R3 commit", 32'(cur_valid), 1);
        chk("R3 slot0 first", 32'(cur_slot), 0);
        end_frame(100);
        rd_chk("R5 count0", 3, 112);
        rd_chk("R5 state0 pending", 2, 2);
        rd_chk("R5 state1 untouched", 4, 1);
        chk("R7 irq high", 32'(rx_irq), 1);
        chk("R2 can_rx slot1", 32'(can_rx), 1);
        start_frame();
        chk("R3 slot1 next", 32'(cur_slot), 1);
        end_frame(30);
        rd_chk("R5 padded count1", 5, 72);
        rd_chk("R5 state1 pending", 4, 2);
        chk("R2 can_rx none", 32'(can_rx), 0);
    endtask

    task automatic t_irq();
        wr(2, 1);
        chk("R7 irq slot1 pending", 32'(rx_irq), 1);
        wr(4, 0);
        chk("R7 irq cleared", 32'(rx_irq), 0);
    endtask

    task automatic t_reject();
        start_frame();
        end_frame(2037);
        rd_chk("R6 state0 kept", 2, 1);
        rd_chk("R6 count0 kept", 3, 112);
        chk("R6 irq low", 32'(rx_irq), 0);
        start_frame();
        end_frame(2036);
        rd_chk("R6 max count0", 3, 2048);
        rd_chk("R6 max state0", 2, 2);
    endtask

    task automatic t_hold();
        wr(2, 0); wr(4, 1);
        start_frame();
        chk("R8 slot1 committed", 32'(cur_slot), 1);
        wr(2, 1);
        chk("R8 still slot1", 32'(cur_slot), 1);
        end_frame(64);
        rd_chk("R8 state1 pending", 4, 2);
        rd_chk("R8 count1", 5, 76);
        rd_chk("R8 state0 loaded", 2, 1);
        chk("R8 released", 32'(cur_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_state_rw();
        t_drop();
        t_receive();
        t_irq();
        t_reject();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule